// File: doc/BRIEF.md
# Priority-Based Throttle Arbiter

This block settles which of several throttle requests controls the clock slowdown applied to a CPU clock domain and a GPU clock domain. Each event slot holds three programmed settings: a numeric priority, a CPU pulse-skip depth in percent, and a two-bit GPU skip level. Slot 0 is the light thermal event, slot 1 is the heavy thermal event and slot 2 is the overcurrent event. Software programs the settings through a single-cycle write port.

Each cycle, the block looks at the request lines and finds the active event with the largest priority. That event supplies both outputs: its CPU depth and its GPU level go to the outputs as a pair. A throttle-active flag marks that some event won. The outputs are registered. With no active event, both settings read zero.

Top module: `thr_arbiter`

## Requirements
- R1: After reset every slot holds priority 0, depth 0 and level 0, and the outputs are cpu_depth 0, gpu_lvl 0 and thr_active low.
- R2: Among events whose request bit is 1 and whose priority is non-zero, the event with the largest priority wins. Both cpu_depth and gpu_lvl come from that one event, and thr_active is high.
- R3: When active events share the largest priority, the event with the lowest slot index wins.
- R4: An event whose priority is 0 never wins and never raises thr_active, even while its request bit is 1.
- R5: With no active event, cpu_depth is 0, gpu_lvl is 0 and thr_active is low.
- R6: The outputs are registered. A change on req shows on the outputs after the next rising clock edge and not before it. A setting written at an edge affects arbitration from the following edge on.
- R7: A write happens when wr_en is 1. wr_evt selects the slot, and wr_field selects the setting: 0 sets the priority, 1 sets the CPU depth and 2 sets the GPU level (0 none, 1 low, 2 medium, 3 high). Field code 3 is ignored, and so is any wr_evt of 3 or more. Neither changes any setting.
- R8: Written values saturate. A priority above 100 is stored as 100, a depth above 100 is stored as 100, and a level above 3 is stored as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Setting write strobe |
| wr_evt | input | 2 | Slot index for the write |
| wr_field | input | 2 | Setting selector: 0 priority, 1 CPU depth, 2 GPU level, 3 reserved |
| wr_data | input | 8 | Write value (saturated when stored) |
| req | input | 3 | Request lines, one per slot (0 light, 1 heavy, 2 overcurrent) |
| cpu_depth | output | 7 | CPU skip depth of the winner, in percent |
| gpu_lvl | output | 2 | GPU skip level of the winner |
| thr_active | output | 1 | High when some event won |

## Verification
The bench programs three distinct priorities and applies all eight request combinations. This shows that a higher priority beats a lower one no matter which slot it sits in, and that the depth and level always arrive together from the same slot. It then sets two slots to the same priority to test the lowest-index tie rule. It sets a slot's priority to zero to show that a request on that slot is dropped. Over-range writes are chosen so that an unsaturated value would be truncated and change the winner. A sample taken just before the clock edge separates the registered output from a combinational path.

// File: rtl/thr_pkg.sv
package thr_pkg;

   // Setting selector codes on the write port
   typedef enum logic [1:0] {
      FLD_PRIO  = 2'd0,
      FLD_CPU   = 2'd1,
      FLD_GPU   = 2'd2,
      FLD_RSVD  = 2'd3
   } thr_fld_e;

   localparam int unsigned PRIO_MAX  = 100;
   localparam int unsigned DEPTH_MAX = 100;

endpackage

// File: rtl/thr_evt_cfg.sv
module thr_evt_cfg #(
   parameter int unsigned PRIO_W  = 7,
   parameter int unsigned DEPTH_W = 7,
   parameter int unsigned LVL_W   = 2,
   parameter int unsigned DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_sel,
   input  logic [1:0]         wr_field,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [PRIO_W-1:0]  prio,
   output logic [DEPTH_W-1:0] depth,
   output logic [LVL_W-1:0]   lvl
);
   import thr_pkg::*;

   localparam logic [DATA_W-1:0] PRIO_LIM  = DATA_W'(PRIO_MAX);
   localparam logic [DATA_W-1:0] DEPTH_LIM = DATA_W'(DEPTH_MAX);
   localparam logic [DATA_W-1:0] LVL_LIM   = DATA_W'((1 << LVL_W) - 1);

   logic [PRIO_W-1:0]  prio_sat;
   logic [DEPTH_W-1:0] depth_sat;
   logic [LVL_W-1:0]   lvl_sat;
   thr_fld_e           fld;

   assign fld = thr_fld_e'(wr_field);

   always_comb begin
      prio_sat  = (wr_data > PRIO_LIM)  ? PRIO_W'(PRIO_MAX)   : wr_data[PRIO_W-1:0];
      depth_sat = (wr_data > DEPTH_LIM) ? DEPTH_W'(DEPTH_MAX) : wr_data[DEPTH_W-1:0];
      lvl_sat   = (wr_data > LVL_LIM)   ? '1                  : wr_data[LVL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio  <= '0;
         depth <= '0;
         lvl   <= '0;
      end else if (wr_sel) begin
         case (fld)
            FLD_PRIO: prio  <= prio_sat;
            FLD_CPU:  depth <= depth_sat;
            FLD_GPU:  lvl   <= lvl_sat;
            default:  ;
         endcase
      end
   end

   AST_PRIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      prio <= PRIO_W'(PRIO_MAX)); // R8
   AST_DEPTH_STORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= DEPTH_W'(DEPTH_MAX)); // R8
   AST_RSVD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && wr_field == 2'd3) |=> ($stable(prio) && $stable(depth) && $stable(lvl))); // R7

endmodule

// File: rtl/thr_prio_select.sv
module thr_prio_select #(
   parameter int unsigned NUM_EVT = 3,
   parameter int unsigned PRIO_W  = 7,
   parameter int unsigned DEPTH_W = 7,
   parameter int unsigned LVL_W   = 2
) (
   input  logic [NUM_EVT-1:0]              req,
   input  logic [NUM_EVT-1:0][PRIO_W-1:0]  prio,
   input  logic [NUM_EVT-1:0][DEPTH_W-1:0] depth,
   input  logic [NUM_EVT-1:0][LVL_W-1:0]   lvl,
   output logic [NUM_EVT-1:0]              grant,
   output logic                            any_act,
   output logic [DEPTH_W-1:0]              sel_depth,
   output logic [LVL_W-1:0]                sel_lvl
);

   logic [NUM_EVT-1:0] act;
   logic [PRIO_W-1:0]  best_p;

   always_comb begin
      for (int i = 0; i < NUM_EVT; i++) begin
         act[i] = req[i] && (prio[i] != '0);
      end
   end

   // Linear scan with strict compare: the first slot holding the top value keeps it
   always_comb begin
      best_p = '0;
      grant  = '0;
      for (int i = 0; i < NUM_EVT; i++) begin
         if (act[i] && (prio[i] > best_p)) begin
            best_p = prio[i];
            grant  = '0;
            grant[i] = 1'b1;
         end
      end
   end

   assign any_act = |grant;

   // AND-OR mux keyed by the one-hot grant
   always_comb begin
      sel_depth = '0;
      sel_lvl   = '0;
      for (int i = 0; i < NUM_EVT; i++) begin
         sel_depth = sel_depth | (depth[i] & {DEPTH_W{grant[i]}});
         sel_lvl   = sel_lvl   | (lvl[i]   & {LVL_W{grant[i]}});
      end
   end

endmodule

// File: rtl/thr_out_reg.sv
module thr_out_reg #(
   parameter int unsigned DEPTH_W = 7,
   parameter int unsigned LVL_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               any_act,
   input  logic [DEPTH_W-1:0] sel_depth,
   input  logic [LVL_W-1:0]   sel_lvl,
   output logic               thr_active,
   output logic [DEPTH_W-1:0] cpu_depth,
   output logic [LVL_W-1:0]   gpu_lvl
);
   import thr_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_active <= 1'b0;
         cpu_depth  <= '0;
         gpu_lvl    <= '0;
      end else begin
         thr_active <= any_act;
         cpu_depth  <= sel_depth;
         gpu_lvl    <= sel_lvl;
      end
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !thr_active |-> (cpu_depth == '0 && gpu_lvl == '0)); // R5
   AST_DEPTH_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_depth <= DEPTH_W'(DEPTH_MAX)); // R8

endmodule

// File: rtl/thr_arbiter.sv
module thr_arbiter #(
   parameter int unsigned NUM_EVT = 3,
   parameter int unsigned PRIO_W  = 7,
   parameter int unsigned DEPTH_W = 7,
   parameter int unsigned LVL_W   = 2,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned EVT_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [EVT_W-1:0]   wr_evt,
   input  logic [1:0]         wr_field,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [NUM_EVT-1:0] req,
   output logic [DEPTH_W-1:0] cpu_depth,
   output logic [LVL_W-1:0]   gpu_lvl,
   output logic               thr_active
);
   import thr_pkg::*;

   // Elaboration checks on parameters
   if (NUM_EVT < 1) begin : g_bad_num
      $error("thr_arbiter: NUM_EVT must be at least 1");
   end
   if (((1 << PRIO_W) - 1) < PRIO_MAX) begin : g_bad_prio
      $error("thr_arbiter: PRIO_W too narrow for the priority range");
   end
   if (((1 << DEPTH_W) - 1) < DEPTH_MAX) begin : g_bad_depth
      $error("thr_arbiter: DEPTH_W too narrow for the depth range");
   end
   if (DATA_W < PRIO_W || DATA_W < DEPTH_W || DATA_W < LVL_W) begin : g_bad_data
      $error("thr_arbiter: DATA_W narrower than a stored setting");
   end

   logic [NUM_EVT-1:0][PRIO_W-1:0]  prio;
   logic [NUM_EVT-1:0][DEPTH_W-1:0] depth;
   logic [NUM_EVT-1:0][LVL_W-1:0]   lvl;
   logic [NUM_EVT-1:0]              grant;
   logic                            any_act;
   logic [DEPTH_W-1:0]              sel_depth;
   logic [LVL_W-1:0]                sel_lvl;

   for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
      logic wr_sel;
      assign wr_sel = wr_en && (wr_evt == EVT_W'(g));
      thr_evt_cfg #(
         .PRIO_W (PRIO_W), .DEPTH_W(DEPTH_W), .LVL_W(LVL_W), .DATA_W(DATA_W)
      ) u_cfg (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_sel  (wr_sel),
         .wr_field(wr_field),
         .wr_data (wr_data),
         .prio    (prio[g]),
         .depth   (depth[g]),
         .lvl     (lvl[g])
      );
   end

   thr_prio_select #(
      .NUM_EVT(NUM_EVT), .PRIO_W(PRIO_W), .DEPTH_W(DEPTH_W), .LVL_W(LVL_W)
   ) u_sel (
      .req      (req),
      .prio     (prio),
      .depth    (depth),
      .lvl      (lvl),
      .grant    (grant),
      .any_act  (any_act),
      .sel_depth(sel_depth),
      .sel_lvl  (sel_lvl)
   );

   thr_out_reg #(.DEPTH_W(DEPTH_W), .LVL_W(LVL_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_act   (any_act),
      .sel_depth (sel_depth),
      .sel_lvl   (sel_lvl),
      .thr_active(thr_active),
      .cpu_depth (cpu_depth),
      .gpu_lvl   (gpu_lvl)
   );

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R2
   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~req) == '0); // R4
   AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(req) == '0) |-> !thr_active); // R5
   AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |=> thr_active); // R6

endmodule

// File: tb/thr_arbiter_bench.sv
module thr_arbiter_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_evt = '0;
   logic [1:0] wr_field = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] req = '0;
   logic [6:0] cpu_depth;
   logic [1:0] gpu_lvl;
   logic       thr_active;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   thr_arbiter u_thr_arbiter (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_evt(wr_evt),
      .wr_field(wr_field), .wr_data(wr_data), .req(req),
      .cpu_depth(cpu_depth), .gpu_lvl(gpu_lvl), .thr_active(thr_active)
   );

   // {req, depth, level, active}; slot0 light 80/50/low, slot1 heavy 100/85/high, slot2 oc 50/75/med
   localparam logic [12:0] VEC [8] = '{
      {3'b000, 7'd0,  2'd0, 1'b0},
      {3'b001, 7'd50, 2'd1, 1'b1},
      {3'b010, 7'd85, 2'd3, 1'b1},
      {3'b011, 7'd85, 2'd3, 1'b1},
      {3'b100, 7'd75, 2'd2, 1'b1},
      {3'b101, 7'd50, 2'd1, 1'b1},
      {3'b110, 7'd85, 2'd3, 1'b1},
      {3'b111, 7'd85, 2'd3, 1'b1}
   };

   task automatic check(string tag, logic [6:0] ed, logic [1:0] el, logic ea);
      n_chk++;
      if (cpu_depth !== ed || gpu_lvl !== el || thr_active !== ea) begin
         n_bad++;
         $display("FAIL %s: got depth=%0d lvl=%0d act=%0b, expected depth=%0d lvl=%0d act=%0b",
                  tag, cpu_depth, gpu_lvl, thr_active, ed, el, ea);
      end
   endtask

   task automatic wr(logic [1:0] e, logic [1:0] f, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_evt = e; wr_field = f; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Drive req at a falling edge, sample at the next falling edge
   task automatic apply(logic [2:0] r);
      @(negedge clk);
      req = r;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", 7'd0, 2'd0, 1'b0);
      rst_n = 1'b1;
      apply(3'b111);
      check("R4 unprogrammed slots", 7'd0, 2'd0, 1'b0);
      apply(3'b000);

      wr(2'd0, 2'd0, 8'd80);  wr(2'd0, 2'd1, 8'd50); wr(2'd0, 2'd2, 8'd1);
      wr(2'd1, 2'd0, 8'd100); wr(2'd1, 2'd1, 8'd85); wr(2'd1, 2'd2, 8'd3);
      wr(2'd2, 2'd0, 8'd50);  wr(2'd2, 2'd1, 8'd75); wr(2'd2, 2'd2, 8'd2);

      for (int i = 0; i < 8; i++) begin
         apply(VEC[i][12:10]);
         check(VEC[i][12:10] == 3'b000 ? "R5 idle" : "R2 table",
               VEC[i][9:3], VEC[i][2:1], VEC[i][0]);
      end

      // R6: before the edge the old value remains, after the edge the new one
      apply(3'b000);
      @(negedge clk);
      req = 3'b100;
      #2;
      check("R6 before edge", 7'd0, 2'd0, 1'b0);
      @(negedge clk);
      check("R6 after edge", 7'd75, 2'd2, 1'b1);

      // R7: reserved field and out-of-range slot change nothing
      wr(2'd2, 2'd3, 8'd9);
      wr(2'd3, 2'd0, 8'd100);
      wr(2'd3, 2'd1, 8'd5);
      apply(3'b100);
      check("R7 ignored writes", 7'd75, 2'd2, 1'b1);

      // R3: equal priority, lower index wins
      wr(2'd2, 2'd0, 8'd100);
      apply(3'b110);
      check("R3 tie slot1 over slot2", 7'd85, 2'd3, 1'b1);

      // R8: saturating priority (200 would truncate to 72) beats 99
      wr(2'd1, 2'd0, 8'd99);
      wr(2'd2, 2'd0, 8'd200);
      apply(3'b110);
      check("R8 prio clamp", 7'd75, 2'd2, 1'b1);

      // R8: depth 120 -> 100, level 7 -> 3
      wr(2'd0, 2'd1, 8'd120);
      wr(2'd0, 2'd2, 8'd7);
      apply(3'b001);
      check("R8 depth and level clamp", 7'd100, 2'd3, 1'b1);

      // R4: priority 0 disables a slot
      wr(2'd1, 2'd0, 8'd0);
      apply(3'b010);
      check("R4 disabled slot", 7'd0, 2'd0, 1'b0);
      apply(3'b011);
      check("R4 disabled slot skipped", 7'd100, 2'd3, 1'b1);

      // R1: reset clears settings
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset outputs", 7'd0, 2'd0, 1'b0);
      rst_n = 1'b1;
      apply(3'b111);
      check("R1 settings cleared", 7'd0, 2'd0, 1'b0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule